// File: doc/BRIEF.md
# Carry-Save Streaming Accumulator

This block adds up a stream of unsigned operands of arbitrary length. It never forms a full-width carry chain inside the loop. The running total is kept as two vectors, a partial sum and a carry word. Each accepted cycle folds the new operands into these two vectors through a chain of 3:2 compressor rows. The depth of that chain grows with the number of lanes and not with the operand width. One cycle therefore takes `LANES` new operands, which is the p-2 operands of a [p:2] reduction with p = `LANES`+2.

A single carry-propagate adder resolves the two registers into a binary result. It sits outside the feedback loop and drives `sum_o` directly. A producer presents operands with `op_valid_i`, enables lanes with `lane_en_i` and marks the final cycle of a stream with `op_last_i`. One cycle later `done_o` pulses and `sum_o` holds the total. The next valid cycle starts a fresh total on its own, so streams can run back to back. `clear_i` abandons a stream at any time.

Top module: `csa_accum`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `done_o` is 0 and `sum_o` is 0.
- R2: The cycle after every accepted cycle (`op_valid_i`=1, `clear_i`=0), `sum_o` equals the unsigned sum of all operands absorbed so far in the current stream. The sum is taken modulo 2^`ACC_W`, where `ACC_W` = `OP_W` + ceil(log2(`MAX_OPS`)).
- R3: In an accepted cycle, lane k carries the operand `op_i[k*OP_W +: OP_W]`. A lane whose `lane_en_i[k]` is 0 adds zero.
- R4: A cycle with `op_valid_i`=0 and `clear_i`=0 leaves `sum_o` unchanged in the following cycle.
- R5: `done_o` is 1 in a cycle exactly when the previous cycle was accepted with `op_last_i`=1. At that point `sum_o` is the total of the finished stream.
- R6: `clear_i`=1 zeroes the total and drops the operands presented in the same cycle. In the next cycle `sum_o` is 0 and `done_o` is 0, whatever the values of `op_valid_i` and `op_last_i`.
- R7: After a stream ends, `sum_o` keeps the finished total until the next accepted cycle. The total after that cycle counts only that cycle's operands.
- R8: A stream of up to `MAX_OPS` operands, each at its maximum value `2^OP_W-1`, gives its exact sum without overflow.
- R9: `op_last_i` has no effect in a cycle where `op_valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous abandon of the current total |
| op_valid_i | input | 1 | Operands on `op_i` are presented this cycle |
| op_last_i | input | 1 | This accepted cycle closes the stream |
| lane_en_i | input | LANES | Per-lane operand enable |
| op_i | input | LANES*OP_W | Packed operands, lane k at bits k*OP_W upward |
| sum_o | output | ACC_W | Resolved running total |
| done_o | output | 1 | Pulse: `sum_o` holds a finished stream total |

## Verification
The bench applies every pair of 4-bit operand values as a one-cycle stream. A design with a misplaced carry weight, or with a half-adder where a full-adder belongs, gives wrong totals for some of these pairs. It then runs random multi-cycle streams with gaps, masked lanes and stray last markers. A design that adds a disabled lane, moves during idle cycles or raises `done_o` on an unaccepted last shows a mismatch there. Streams of maximum-value operands up to the operand limit expose a total that is too narrow. Clear is applied mid-stream and together with a valid last. This catches designs that let the colliding operand through, or that carry the old total into the next stream.

// File: rtl/csa_pkg.sv
package csa_pkg;
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/csa_row.sv
// One 3:2 compressor row; carry word is pre-shifted, top carry discarded (mod 2^W).
module csa_row
  import csa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  assign c_o[0] = 1'b0;
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign s_o[b] = fa_sum(x_i[b], y_i[b], z_i[b]);
    if (b > 0) begin : g_cy
      assign c_o[b] = fa_carry(x_i[b-1], y_i[b-1], z_i[b-1]);
    end
  end
endmodule

// File: rtl/csa_tree.sv
// Linear array of 3:2 rows reducing N_IN words to a sum/carry pair.
module csa_tree #(
  parameter int W    = 8,
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0][W-1:0] in_i,
  output logic [W-1:0]           s_o,
  output logic [W-1:0]           c_o
);
  localparam int N_ROW = N_IN - 2;

  logic [N_ROW-1:0][W-1:0] s_w;
  logic [N_ROW-1:0][W-1:0] c_w;

  for (genvar k = 0; k < N_ROW; k++) begin : g_row
    if (k == 0) begin : g_first
      csa_row #(.W(W)) i_row (
        .x_i(in_i[0]), .y_i(in_i[1]), .z_i(in_i[2]),
        .s_o(s_w[k]),  .c_o(c_w[k])
      );
    end else begin : g_next
      csa_row #(.W(W)) i_row (
        .x_i(s_w[k-1]), .y_i(c_w[k-1]), .z_i(in_i[k+2]),
        .s_o(s_w[k]),   .c_o(c_w[k])
      );
    end
  end

  assign s_o = s_w[N_ROW-1];
  assign c_o = c_w[N_ROW-1];
endmodule

// File: rtl/csa_cpa.sv
// Final resolving adder, outside the accumulation loop.
module csa_cpa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  assign y_o = a_i + b_i;
endmodule

// File: rtl/csa_accum.sv
module csa_accum #(
  parameter int OP_W    = 16,
  parameter int LANES   = 2,
  parameter int MAX_OPS = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  op_valid_i,
  input  logic                  op_last_i,
  input  logic [LANES-1:0]      lane_en_i,
  input  logic [LANES*OP_W-1:0] op_i,
  output logic [OP_W+$clog2(MAX_OPS)-1:0] sum_o,
  output logic                  done_o
);
  localparam int ACC_W = OP_W + $clog2(MAX_OPS);
  localparam int N_IN  = LANES + 2;
  localparam int PAD_W = ACC_W - OP_W;

  logic [ACC_W-1:0] ps_q, cy_q, ps_d, cy_d;
  logic             fresh_q, done_q;
  logic [N_IN-1:0][ACC_W-1:0] tree_in;

  // fresh_q: next accepted cycle starts from zero instead of the stored total
  assign tree_in[0] = fresh_q ? '0 : ps_q;
  assign tree_in[1] = fresh_q ? '0 : cy_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign tree_in[k+2] = lane_en_i[k] ? {{PAD_W{1'b0}}, op_i[k*OP_W +: OP_W]} : '0;
  end

  csa_tree #(.W(ACC_W), .N_IN(N_IN)) i_tree (
    .in_i(tree_in),
    .s_o (ps_d),
    .c_o (cy_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q    <= '0;
      cy_q    <= '0;
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (clear_i) begin
      ps_q    <= '0;
      cy_q    <= '0;
      fresh_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= op_valid_i & op_last_i;
      if (op_valid_i) begin
        ps_q    <= ps_d;
        cy_q    <= cy_d;
        fresh_q <= op_last_i;
      end
    end
  end

  csa_cpa #(.W(ACC_W)) i_cpa (
    .a_i(ps_q),
    .b_i(cy_q),
    .y_o(sum_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/csa_accum_chk.sv
module csa_accum_chk #(
  parameter int ACC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             op_valid_i,
  input logic             op_last_i,
  input logic [ACC_W-1:0] sum_o,
  input logic             done_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!done_o); // R1
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !clear_i) |=> $stable(sum_o)); // R4

  AST_DONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(op_valid_i && op_last_i && !clear_i)); // R5

  AST_DONE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_last_i && !clear_i) |=> done_o); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_o == '0) && !done_o); // R6

  AST_STRAY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_last_i && !op_valid_i) |=> !done_o); // R9
endmodule

bind csa_accum csa_accum_chk #(.ACC_W(ACC_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .op_valid_i(op_valid_i),
  .op_last_i (op_last_i),
  .sum_o     (sum_o),
  .done_o    (done_o)
);

// File: tb/test_csa_accum.sv
`timescale 1ns/1ps
module test_csa_accum;
  localparam int OP_W    = 4;
  localparam int LANES   = 2;
  localparam int MAX_OPS = 16;
  localparam int ACC_W   = OP_W + $clog2(MAX_OPS);

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  clear_i = 1'b0;
  logic                  op_valid_i = 1'b0;
  logic                  op_last_i = 1'b0;
  logic [LANES-1:0]      lane_en_i = '0;
  logic [LANES*OP_W-1:0] op_i = '0;
  logic [ACC_W-1:0]      sum_o;
  logic                  done_o;

  int n_chk = 0;
  int n_bad = 0;
  int acc   = 0;
  bit fresh = 1'b1;

  always #4 clk = ~clk;

  csa_accum #(.OP_W(OP_W), .LANES(LANES), .MAX_OPS(MAX_OPS)) i_csa_accum (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .op_valid_i(op_valid_i),
    .op_last_i(op_last_i), .lane_en_i(lane_en_i), .op_i(op_i),
    .sum_o(sum_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model per requirements, sample at next negedge
  task automatic cyc(input bit clr, input bit v, input bit l, input logic [1:0] en,
                     input int a, input int b, input string req);
    bit exp_done;
    clear_i = clr; op_valid_i = v; op_last_i = l; lane_en_i = en;
    op_i = {4'(b), 4'(a)};
    @(negedge clk);
    if (clr) begin
      acc = 0; fresh = 1'b1; exp_done = 1'b0;
    end else begin
      exp_done = v && l;                         // R5 R9
      if (v) begin
        if (fresh) acc = 0;                      // R7
        acc += (en[0] ? a : 0) + (en[1] ? b : 0); // R3
        fresh = l;
      end
    end
    acc = acc % (1 << ACC_W);
    check(done_o == exp_done, {req, " done"}, int'(done_o), int'(exp_done));
    check(int'(sum_o) == acc, {req, " sum"}, int'(sum_o), acc);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 1'b0, 1'b0, 2'b00, 0, 0, req);
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    check(sum_o == '0, "R1 sum in reset", int'(sum_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle("R1");

    // R2 R3: every operand pair as a one-cycle stream
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        cyc(1'b0, 1'b1, 1'b1, 2'b11, a, b, "R2");
        if (((a + b) % 7) == 0) idle("R7 hold");
      end

    // R3: masked lanes
    cyc(1'b0, 1'b1, 1'b0, 2'b01, 9, 15, "R3");
    cyc(1'b0, 1'b1, 1'b0, 2'b10, 15, 6, "R3");
    cyc(1'b0, 1'b1, 1'b1, 2'b00, 15, 15, "R3");

    // R8: full-scale streams up to the operand limit
    for (int n = 1; n <= MAX_OPS / LANES; n++)
      for (int k = 0; k < n; k++)
        cyc(1'b0, 1'b1, k == n - 1, 2'b11, 15, 15, "R8");

    // R6: clear mid-stream and clear colliding with valid last
    cyc(1'b0, 1'b1, 1'b0, 2'b11, 7, 8, "R6");
    cyc(1'b1, 1'b1, 1'b1, 2'b11, 3, 3, "R6");
    cyc(1'b0, 1'b1, 1'b1, 2'b11, 2, 5, "R6");
    cyc(1'b1, 1'b0, 1'b0, 2'b00, 0, 0, "R6");

    // R9: stray last during a stream
    cyc(1'b0, 1'b1, 1'b0, 2'b11, 4, 4, "R9");
    cyc(1'b0, 1'b0, 1'b1, 2'b11, 9, 9, "R9");
    cyc(1'b0, 1'b1, 1'b1, 2'b01, 1, 9, "R9");

    // random streams with gaps, masks, stray lasts and occasional clear
    for (int s = 0; s < 300; s++) begin
      int ncyc = $urandom_range(1, MAX_OPS / LANES);
      for (int k = 0; k < ncyc; k++) begin
        if ($urandom_range(0, 3) == 0)
          cyc(1'b0, 1'b0, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
              $urandom_range(0, 15), $urandom_range(0, 15), "R4");
        if ($urandom_range(0, 40) == 0)
          cyc(1'b1, 1'($urandom_range(0, 1)), 1'b0, 2'b11, 5, 5, "R6");
        cyc(1'b0, 1'b1, k == ncyc - 1, 2'($urandom_range(0, 3)),
            $urandom_range(0, 15), $urandom_range(0, 15), "R2");
      end
    end
    idle("R7");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule